// File: doc/BRIEF.md
# Interlaced Video Sync Generator

This block counts the beam position of a television raster in color-clock steps and derives from that position every sync and blanking signal a PAL or NTSC display needs. A horizontal counter walks each line and a vertical counter walks each frame. With interlace enabled, the frame length alternates between a long and a short field. In NTSC mode the line length also alternates between a short and a long line.

The counters move only when the color-clock enable is high. The sync outputs are decoded without extra registers from the current position, the standard select and the field type. The decode produces horizontal sync and vertical sync. It also produces composite sync, which carries narrow pulses while vertical sync is active. The remaining outputs are vertical blank and the equalization-zone window. The standard select may change between frames or within a frame. The counters adopt the new line and frame limits at the next line end.

Top module: `vidsync_gen`

## Requirements
- R1: A synchronous reset, which acts on any clock edge whether or not `cke` is high, sets `hpos` to 0, `vpos` to 0, `long_frame` to 1 and `long_line` to 0.
- R2: While `cke` is low, `hpos`, `vpos`, `long_frame` and `long_line` keep their values.
- R3: A line ends when `hpos` reaches 226, or 227 when `pal_mode` is 0 and `long_line` is 1. A PAL line therefore lasts 227 enabled clocks. After reset, NTSC lines last 227 and 228 in turn. At each line end `hpos` returns to 0. At the same edge `long_line` inverts in NTSC mode and clears in PAL mode.
- R4: At the end of the last line of a frame, `vpos` returns to 0; at any other line end it increments. The last line is 312 (PAL, long frame), 311 (PAL, short frame), 262 (NTSC, long frame) or 261 (NTSC, short frame). A line at or beyond the last line also ends the frame.
- R5: When a frame ends, `long_frame` inverts if `lace_en` is 1 and keeps its value if `lace_en` is 0.
- R6: `hsync` is 1 exactly for `hpos` 18 through 34.
- R7: `vsync` is 1 inside a (line, count) window whose start is included and whose end is excluded. PAL long frame: from (2,132) to (5,18). PAL short frame: from (3,18) to (5,132). NTSC long frame: from (3,18) to (6,18). NTSC short frame: from (3,132) to (6,132).
- R8: `csync` equals `hsync` while `vsync` is 0. While `vsync` is 1, `csync` is 1 for counts 18 up to 25 (PAL) or 26 (NTSC), and for counts 132 up to 139 (PAL) or 140 (NTSC).
- R9: `vblank` is 1 from count 1 of the last line of the frame up to, but not including, count 1 of line 25 (PAL) or line 20 (NTSC).
- R10: `equ_zone` starts on line 0 and ends on line 8 (PAL long frame), line 7 (PAL short frame) or line 9 (NTSC). On a long frame it starts at count 115 and ends at count 9. On a short frame it starts at count 9 and ends at count 115.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Color-clock enable; counters step when high |
| pal_mode | input | 1 | 1 selects PAL timing, 0 selects NTSC |
| lace_en | input | 1 | 1 makes the field type alternate every frame |
| hpos | output | 8 | Horizontal beam count within the line |
| vpos | output | 9 | Line number within the frame |
| long_frame | output | 1 | Current frame is the long field |
| long_line | output | 1 | Current NTSC line is the long one |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| csync | output | 1 | Composite sync, active high |
| vblank | output | 1 | Vertical blank, active high |
| equ_zone | output | 1 | Equalization-zone window, active high |

## Verification
The bench builds the block with its default widths of 8 and 9 bits. At these widths the real 227/228-clock lines and 262 to 313-line frames are counted exactly. Running a whole PAL long frame with the enable high on every clock fits the cycle budget. The bench switches the standard at line 30 of a frame, which brings the NTSC last-line wrap within reach in the same run. It clears interlace just before a frame end to show that the field type holds. It also reapplies reset in the middle of a frame, so the NTSC long-frame start and the alternating NTSC line lengths are measured from a known state.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  localparam int H_W = 8;
  localparam int V_W = 9;

  localparam int HS_ON    = 18;
  localparam int HS_OFF   = 35;
  localparam int H_MID    = 132;
  localparam int VB_H     = 1;
  localparam int EQ_H_EARLY = 9;
  localparam int EQ_H_LATE  = 115;

  // last count of the current line
  function automatic int line_last(input logic pal, input logic longl);
    return (!pal && longl) ? 227 : 226;
  endfunction

  // last line of the current frame
  function automatic int frame_last(input logic pal, input logic lf);
    if (pal) return lf ? 312 : 311;
    return lf ? 262 : 261;
  endfunction

  function automatic int vblank_stop_line(input logic pal);
    return pal ? 25 : 20;
  endfunction

  // end (exclusive) of a narrow pulse starting at base
  function automatic int pulse_end(input logic pal, input int base);
    return base + (pal ? 8 : 9);
  endfunction

  function automatic int equ_last_line(input logic pal, input logic lf);
    if (pal) return lf ? 8 : 7;
    return 9;
  endfunction

  // (line,count) inside [start, stop) in raster order
  function automatic logic in_span(input int ln, input int ct,
                                   input int l0, input int c0,
                                   input int l1, input int c1);
    int p, a, b;
    p = ln * (1 << H_W) + ct;
    a = l0 * (1 << H_W) + c0;
    b = l1 * (1 << H_W) + c1;
    return (p >= a) && (p < b);
  endfunction

endpackage

// File: rtl/vsg_beam_counter.sv
module vsg_beam_counter #(
  parameter int HW = vsg_pkg::H_W,
  parameter int VW = vsg_pkg::V_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cke,
  input  logic          pal_mode,
  input  logic          lace_en,
  output logic [HW-1:0] hpos,
  output logic [VW-1:0] vpos,
  output logic          long_frame,
  output logic          long_line,
  output logic          line_end,
  output logic          frame_end
);
  import vsg_pkg::*;

  always_comb begin
    line_end  = int'(hpos) >= line_last(pal_mode, long_line);
    frame_end = int'(vpos) >= frame_last(pal_mode, long_frame);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hpos       <= '0;
      vpos       <= '0;
      long_frame <= 1'b1;
      long_line  <= 1'b0;
    end else if (cke) begin
      if (line_end) begin
        hpos      <= '0;
        long_line <= pal_mode ? 1'b0 : ~long_line;
        if (frame_end) begin
          vpos <= '0;
          if (lace_en) long_frame <= ~long_frame;
        end else begin
          vpos <= vpos + 1'b1;
        end
      end else begin
        hpos <= hpos + 1'b1;
      end
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cke |=> $stable(hpos) && $stable(vpos) && $stable(long_frame) && $stable(long_line));

  p_hrange_r3: assert property (@(posedge clk) disable iff (rst)
    int'(hpos) <= 227);

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    cke && line_end && frame_end |=> vpos == '0);

  p_lace_r5: assert property (@(posedge clk) disable iff (rst)
    cke && line_end && frame_end && lace_en |=> long_frame != $past(long_frame));

  p_nolace_r5: assert property (@(posedge clk) disable iff (rst)
    cke && line_end && frame_end && !lace_en |=> $stable(long_frame));

endmodule

// File: rtl/vsg_sync_decode.sv
module vsg_sync_decode #(
  parameter int HW = vsg_pkg::H_W,
  parameter int VW = vsg_pkg::V_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hpos,
  input  logic [VW-1:0] vpos,
  input  logic          pal_mode,
  input  logic          long_frame,
  output logic          hsync,
  output logic          vsync,
  output logic          csync,
  output logic          vblank,
  output logic          equ_zone
);
  import vsg_pkg::*;

  int  h, v, last, eql;
  logic narrow;

  always_comb begin
    h    = int'(hpos);
    v    = int'(vpos);
    last = frame_last(pal_mode, long_frame);
    eql  = equ_last_line(pal_mode, long_frame);

    hsync = (h >= HS_ON) && (h < HS_OFF);

    case ({pal_mode, long_frame})
      2'b11:   vsync = in_span(v, h, 2, H_MID, 5, HS_ON);
      2'b10:   vsync = in_span(v, h, 3, HS_ON, 5, H_MID);
      2'b01:   vsync = in_span(v, h, 3, HS_ON, 6, HS_ON);
      default: vsync = in_span(v, h, 3, H_MID, 6, H_MID);
    endcase

    narrow = ((h >= HS_ON) && (h < pulse_end(pal_mode, HS_ON))) ||
             ((h >= H_MID) && (h < pulse_end(pal_mode, H_MID)));
    csync  = vsync ? narrow : hsync;

    vblank = ((v == last) && (h >= VB_H)) ||
             in_span(v, h, 0, 0, vblank_stop_line(pal_mode), VB_H);

    equ_zone = long_frame ? in_span(v, h, 0, EQ_H_LATE, eql, EQ_H_EARLY)
                          : in_span(v, h, 0, EQ_H_EARLY, eql, EQ_H_LATE);
  end

  p_hs_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |-> int'(hpos) == HS_ON);

  p_vs_lines_r7: assert property (@(posedge clk) disable iff (rst)
    vsync |-> (int'(vpos) >= 2) && (int'(vpos) <= 6));

  p_cs_extra_r8: assert property (@(posedge clk) disable iff (rst)
    csync && !hsync |-> vsync);

  p_vs_blank_r9: assert property (@(posedge clk) disable iff (rst)
    vsync |-> vblank);

  p_vs_equ_r10: assert property (@(posedge clk) disable iff (rst)
    vsync |-> equ_zone);

endmodule

// File: rtl/vidsync_gen.sv
module vidsync_gen #(
  parameter int HW = vsg_pkg::H_W,
  parameter int VW = vsg_pkg::V_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cke,
  input  logic          pal_mode,
  input  logic          lace_en,
  output logic [HW-1:0] hpos,
  output logic [VW-1:0] vpos,
  output logic          long_frame,
  output logic          long_line,
  output logic          hsync,
  output logic          vsync,
  output logic          csync,
  output logic          vblank,
  output logic          equ_zone
);

  logic line_end_w;
  logic frame_end_w;

  vsg_beam_counter #(.HW(HW), .VW(VW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .cke        (cke),
    .pal_mode   (pal_mode),
    .lace_en    (lace_en),
    .hpos       (hpos),
    .vpos       (vpos),
    .long_frame (long_frame),
    .long_line  (long_line),
    .line_end   (line_end_w),
    .frame_end  (frame_end_w)
  );

  vsg_sync_decode #(.HW(HW), .VW(VW)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .hpos       (hpos),
    .vpos       (vpos),
    .pal_mode   (pal_mode),
    .long_frame (long_frame),
    .hsync      (hsync),
    .vsync      (vsync),
    .csync      (csync),
    .vblank     (vblank),
    .equ_zone   (equ_zone)
  );

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (hpos == '0) && (vpos == '0) && long_frame && !long_line);

  p_line_step_r4: assert property (@(posedge clk) disable iff (rst)
    cke && line_end_w && !frame_end_w |=> int'(vpos) == int'($past(vpos)) + 1);

endmodule

// File: tb/sim_vidsync_gen.sv
module sim_vidsync_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke = 1'b0;
  logic       pal = 1'b1;
  logic       lace = 1'b1;
  logic [7:0] hpos;
  logic [8:0] vpos;
  logic       long_frame, long_line, hsync, vsync, csync, vblank, equ_zone;

  int checks = 0;
  int errors = 0;
  int mh = 0, mv = 0;
  bit mlf = 1'b1, mll = 1'b0;

  always #2 clk = ~clk;

  vidsync_gen u0 (
    .clk(clk), .rst(rst), .cke(cke), .pal_mode(pal), .lace_en(lace),
    .hpos(hpos), .vpos(vpos), .long_frame(long_frame), .long_line(long_line),
    .hsync(hsync), .vsync(vsync), .csync(csync), .vblank(vblank), .equ_zone(equ_zone)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (line %0d count %0d)", tag, act, exp, mv, mh);
    end
  endtask

  // expected outputs, written line by line from the requirements
  function automatic bit e_hs(int h);
    return h > 17 && h < 35;
  endfunction

  function automatic bit e_vs(bit p, bit lf, int v, int h);
    if (p && lf) return (v == 2 && h >= 132) || v == 3 || v == 4 || (v == 5 && h < 18);
    if (p)       return (v == 3 && h >= 18) || v == 4 || (v == 5 && h < 132);
    if (lf)      return (v == 3 && h >= 18) || v == 4 || v == 5 || (v == 6 && h < 18);
    return (v == 3 && h >= 132) || v == 4 || v == 5 || (v == 6 && h < 132);
  endfunction

  function automatic bit e_cs(bit p, bit lf, int v, int h);
    int w1, w2;
    w1 = p ? 26 : 27;
    w2 = p ? 140 : 141;
    if (e_vs(p, lf, v, h)) return (h >= 18 && h < w1) || (h >= 132 && h < w2);
    return e_hs(h);
  endfunction

  function automatic bit e_vb(bit p, bit lf, int v, int h);
    int lst, stp;
    lst = p ? (lf ? 312 : 311) : (lf ? 262 : 261);
    stp = p ? 25 : 20;
    return (v == lst && h >= 1) || v < stp || (v == stp && h == 0);
  endfunction

  function automatic bit e_eq(bit p, bit lf, int v, int h);
    int hon, hoff, ev;
    hon  = lf ? 115 : 9;
    hoff = lf ? 9 : 115;
    ev   = p ? (lf ? 8 : 7) : 9;
    return (v == 0 && h >= hon) || (v > 0 && v < ev) || (v == ev && h < hoff);
  endfunction

  task automatic model_step();
    int len, lst;
    if (rst) begin
      mh = 0; mv = 0; mlf = 1'b1; mll = 1'b0;
    end else if (cke) begin
      len = pal ? 227 : (mll ? 228 : 227);
      if (mh + 1 >= len) begin
        mh = 0;
        lst = pal ? (mlf ? 312 : 311) : (mlf ? 262 : 261);
        mll = pal ? 1'b0 : ~mll;
        if (mv >= lst) begin
          mv = 0;
          if (lace) mlf = ~mlf;
        end else begin
          mv = mv + 1;
        end
      end else begin
        mh = mh + 1;
      end
    end
  endtask

  task automatic compare_all();
    chk("R3 hpos", int'(hpos), mh);
    chk("R4 vpos", int'(vpos), mv);
    chk("R5 long_frame", int'(long_frame), int'(mlf));
    chk("R3 long_line", int'(long_line), int'(mll));
    chk("R6 hsync", int'(hsync), int'(e_hs(mh)));
    chk("R7 vsync", int'(vsync), int'(e_vs(pal, mlf, mv, mh)));
    chk("R8 csync", int'(csync), int'(e_cs(pal, mlf, mv, mh)));
    chk("R9 vblank", int'(vblank), int'(e_vb(pal, mlf, mv, mh)));
    chk("R10 equ_zone", int'(equ_zone), int'(e_eq(pal, mlf, mv, mh)));
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_to_line(int ln);
    while (mv != ln) tick();
  endtask

  // R1: reset with the enable low
  task automatic t_reset();
    rst = 1'b1; cke = 1'b0; pal = 1'b1; lace = 1'b1;
    tick(); tick();
    chk("R1 hpos after reset", int'(hpos), 0);
    chk("R1 vpos after reset", int'(vpos), 0);
    chk("R1 long_frame after reset", int'(long_frame), 1);
    chk("R1 long_line after reset", int'(long_line), 0);
    rst = 1'b0;
  endtask

  // R2: enable low freezes, half-rate enable halves the advance
  task automatic t_hold();
    cke = 1'b0;
    repeat (6) tick();
    chk("R2 frozen hpos", int'(hpos), 0);
    for (int i = 0; i < 400; i++) begin
      cke = (i % 2 == 0);
      tick();
    end
    chk("R2 half-rate hpos", int'(hpos), 200);
    chk("R2 half-rate vpos", int'(vpos), 0);
    cke = 1'b1;
  endtask

  // R3 R4 R5: full PAL long frame with interlace
  task automatic t_pal_long_frame();
    int maxv = 0;
    int n;
    run_to_line(1);
    n = 0;
    do begin tick(); n++; end while (mv != 2);
    chk("R3 PAL line length", n, 227);
    do begin
      tick();
      if (int'(vpos) > maxv) maxv = int'(vpos);
    end while (!(mv == 0 && mh == 0));
    chk("R4 PAL long last line", maxv, 312);
    chk("R5 field toggles to short", int'(long_frame), 0);
  endtask

  // R4 R5: PAL short start, NTSC short end, interlace off holds
  task automatic t_switch_to_ntsc();
    int maxv = 0;
    run_to_line(30);
    pal = 1'b0;
    run_to_line(200);
    lace = 1'b0;
    do begin
      tick();
      if (int'(vpos) > maxv) maxv = int'(vpos);
    end while (!(mv == 0 && mh == 0));
    chk("R4 NTSC short last line", maxv, 261);
    chk("R5 field held short", int'(long_frame), 0);
    run_to_line(30);
    chk("R5 still short", int'(long_frame), 0);
  endtask

  // R1 R3: mid-frame reset, NTSC long start and line alternation
  task automatic t_ntsc_long_start();
    int n;
    rst = 1'b1; pal = 1'b0; lace = 1'b1;
    tick();
    chk("R1 mid-frame reset vpos", int'(vpos), 0);
    chk("R1 mid-frame reset field", int'(long_frame), 1);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      n = 0;
      do begin tick(); n++; end while (hpos != 8'd0);
      chk("R3 NTSC line length", n, (k % 2 == 0) ? 227 : 228);
    end
    run_to_line(31);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_hold();
    t_pal_long_frame();
    t_switch_to_ntsc();
    t_ntsc_long_start();
    summary();
    $finish;
  end

endmodule